// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block sits beside a processor core and counts what happens inside it. It has one dedicated cycle counter and a parameter-set number of general counters. Each general counter watches one line of an event pulse bus, chosen by the event number in its own type register. Software reaches all of this through a small word-addressed register port. A read returns its data on the clock after the request.

A general counter is not addressed directly. Software first writes a counter index into a select register. The indirect type and value registers then act on that counter. The cycle counter has a value register of its own. Counter enables and interrupt enables each have a pair of registers, one that sets bits and one that clears them. A general counter counts only when the current privilege level passes the filter bits in its type register. The cycle counter can be slowed by a factor of 64, and it can be held while the core is in debug halt. When a counter wraps, it sets a flag in a write-one-to-clear overflow register. All counters share one interrupt line.

Register addresses (word offsets on `bus_addr`): 0 control, 1 counter select, 2 indirect event type, 3 indirect counter value, 4 cycle counter value, 5 enable-set, 6 enable-clear, 7 interrupt-enable-set, 8 interrupt-enable-clear, 9 overflow status.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset, all counters, type registers, the select register, both enable masks and the overflow status are zero. `irq` and `bus_rdata` are low.
- R2: Control bit 0 is the global enable, bit 3 is the divide-by-64 mode, bit 4 is a stored spare bit, and bit 5 is the debug-halt stop. Of the control bits, only bits 0, 3, 4 and 5 are kept. Bits 1 and 2 read as 0. Bits 15:11 always read as NCNT, and every other bit reads as 0.
- R3: Writing control with bit 1 set zeroes every general counter in that cycle. Writing control with bit 2 set zeroes the cycle counter and its divide-by-64 prescaler in that cycle.
- R4: General counter n adds 1 on each clock where all of these hold: the global enable is set, enable bit n is set, `evt_in` is high at the event number in type bits 9:0, and the privilege filter passes. An event number of EVT_W or above never counts.
- R5: The privilege filter uses `priv_lvl`. At level 0 (user), type bit 30 suppresses counting. At level 1 (kernel), type bit 31 suppresses counting. At level 2 (hypervisor), the counter counts only if type bit 27 is set. Level 3 never counts.
- R6: A type register keeps only the bits set in mask 0xC80003FF. All other bits read as 0.
- R7: The cycle counter is eligible on a clock when the global enable and enable bit 31 are set, and not (control bit 5 and `dbg_halt`). An eligible clock adds 1 when bit 3 is clear. When bit 3 is set, the counter adds 1 on every 64th eligible clock.
- R8: Writing the set register ORs the written bits into its mask, and writing the clear register removes them. Reading either register of a pair returns the mask. Only bit 31 and bits NCNT-1:0 exist; all others read 0.
- R9: A counter that increments from 0xFFFFFFFF goes to 0 and sets its overflow flag: bit 31 for the cycle counter, bit n for general counter n. Writing 1s to the status register clears the matching flags. A wrap in the same cycle wins over the clear.
- R10: `irq` is high on the clock after any overflow flag is set together with its interrupt enable. It stays high until that condition ends.
- R11: With a select value of NCNT or above, indirect reads return 0 and indirect writes change nothing.
- R12: A read request returns, on the next clock, the value the register held before that edge. A software write to a counter in the same cycle as an increment takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the clock after `bus_rd` |
| evt_in | input | EVT_W | Event pulses, one line per event number |
| priv_lvl | input | 2 | Current privilege level (0 user, 1 kernel, 2 hypervisor, 3 other) |
| dbg_halt | input | 1 | Core is halted in debug |
| irq | output | 1 | Shared overflow interrupt |

## Verification
The bench targets these corner cases:
- A counter wrapping from all ones. A design without overflow handling would leave the flag clear, leave the counter stuck, or keep `irq` low.
- A clear written in the same cycle as a wrap. A design that ordered these the wrong way would drop the new flag.
- The four privilege levels against each filter bit. A design that swapped the kernel and user bits, or counted hypervisor activity by default, would show wrong counts.
- A select value past the last counter. A design that aliased the index would corrupt a real counter.
- Divide-by-64 mode and debug stall. Any error in the prescaler phase or the stall gate makes the cycle count drift from the model within a few dozen clocks.
- A software write racing an event. If the increment won, the counter would end one higher than the written value.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam logic [3:0] A_CTRL  = 4'd0;
  localparam logic [3:0] A_SEL   = 4'd1;
  localparam logic [3:0] A_TYPE  = 4'd2;
  localparam logic [3:0] A_EVCNT = 4'd3;
  localparam logic [3:0] A_CYC   = 4'd4;
  localparam logic [3:0] A_ENSET = 4'd5;
  localparam logic [3:0] A_ENCLR = 4'd6;
  localparam logic [3:0] A_IESET = 4'd7;
  localparam logic [3:0] A_IECLR = 4'd8;
  localparam logic [3:0] A_OVF   = 4'd9;

  localparam int CB_EN   = 0;
  localparam int CB_EVRST = 1;
  localparam int CB_CYRST = 2;
  localparam int CB_DIV  = 3;
  localparam int CB_SPARE = 4;
  localparam int CB_DBGSTOP = 5;

  localparam int CYC_BIT = 31;
  localparam logic [31:0] TYPE_WMASK = 32'hC800_03FF;
  localparam int TB_NOKERN = 31;
  localparam int TB_NOUSER = 30;
  localparam int TB_HYP    = 27;
endpackage

// File: rtl/pmu_evt_counter.sv
module pmu_evt_counter #(
  parameter int EVT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gate,
  input  logic [EVT_W-1:0] evt,
  input  logic [1:0]       priv,
  input  logic             typ_we,
  input  logic             cnt_we,
  input  logic             clr,
  input  logic [31:0]      wdata,
  output logic [31:0]      cnt,
  output logic [31:0]      typ,
  output logic             wrap
);
  import pmu_pkg::*;
  localparam int EIW = (EVT_W > 1) ? $clog2(EVT_W) : 1;

  logic [31:0] cnt_q, typ_q;
  logic [9:0]  evnum;
  logic        hit, pass, inc;

  always_comb begin
    evnum = typ_q[9:0];
    hit   = ({22'd0, evnum} < 32'(EVT_W)) ? evt[evnum[EIW-1:0]] : 1'b0;
    unique case (priv)
      2'd0:    pass = !typ_q[TB_NOUSER];
      2'd1:    pass = !typ_q[TB_NOKERN];
      2'd2:    pass = typ_q[TB_HYP];
      default: pass = 1'b0;
    endcase
    inc  = gate && hit && pass;
    wrap = inc && (&cnt_q) && !cnt_we && !clr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      typ_q <= '0;
    end else begin
      if (typ_we) typ_q <= wdata & TYPE_WMASK;
      if (clr)         cnt_q <= '0;
      else if (cnt_we) cnt_q <= wdata;
      else if (inc)    cnt_q <= cnt_q + 32'd1;
    end
  end

  assign cnt = cnt_q;
  assign typ = typ_q;

  AST_EVT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!cnt_we && !clr) |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 32'd1)); // R4
  AST_EVT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!gate && !cnt_we && !clr) |=> $stable(cnt_q)); // R4
endmodule

// File: rtl/pmu_cycle_counter.sv
module pmu_cycle_counter #(
  parameter int DIV_LOG2 = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        gate,
  input  logic        div_on,
  input  logic        stall,
  input  logic        cnt_we,
  input  logic        clr,
  input  logic [31:0] wdata,
  output logic [31:0] cnt,
  output logic        wrap
);
  logic [31:0]         cnt_q;
  logic [DIV_LOG2-1:0] presc_q;
  logic                elig, step;

  always_comb begin
    elig = gate && !stall;
    step = elig && (!div_on || (&presc_q));
    wrap = step && (&cnt_q) && !cnt_we && !clr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      presc_q <= '0;
    end else begin
      if (clr)                 presc_q <= '0;
      else if (elig && div_on) presc_q <= presc_q + 1'b1;
      if (clr)         cnt_q <= '0;
      else if (cnt_we) cnt_q <= wdata;
      else if (step)   cnt_q <= cnt_q + 32'd1;
    end
  end

  assign cnt = cnt_q;

  AST_CYC_STALL: assert property (@(posedge clk) disable iff (rst)
    (stall && !cnt_we && !clr) |=> $stable(cnt_q)); // R7
  AST_CYC_DIV: assert property (@(posedge clk) disable iff (rst)
    (div_on && !(&presc_q) && !cnt_we && !clr) |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit #(
  parameter int NCNT  = 4,
  parameter int EVT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [3:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [EVT_W-1:0] evt_in,
  input  logic [1:0]       priv_lvl,
  input  logic             dbg_halt,
  output logic             irq
);
  import pmu_pkg::*;
  localparam logic [31:0] CNT_MASK = 32'h8000_0000 | ((32'd1 << NCNT) - 32'd1);
  localparam logic [4:0]  NCNT5    = 5'(NCNT);

  logic        ctrl_e, ctrl_d, ctrl_x, ctrl_dp;
  logic [4:0]  sel_q;
  logic [31:0] cnten_q, inten_q, ovf_q, rdata_q;
  logic        irq_q;

  logic wr_ctrl, wr_sel, wr_type, wr_evcnt, wr_cyc, wr_ovf;
  logic ev_clr, cy_clr;
  logic [31:0] cnt_arr [NCNT];
  logic [31:0] typ_arr [NCNT];
  logic [NCNT-1:0] evt_wrap;
  logic        cyc_wrap;
  logic [31:0] wrap_vec, cyc_cnt, ind_cnt, ind_typ, rd_mux, ctrl_rd;

  always_comb begin
    wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    wr_sel   = bus_wr && (bus_addr == A_SEL);
    wr_type  = bus_wr && (bus_addr == A_TYPE);
    wr_evcnt = bus_wr && (bus_addr == A_EVCNT);
    wr_cyc   = bus_wr && (bus_addr == A_CYC);
    wr_ovf   = bus_wr && (bus_addr == A_OVF);
    ev_clr   = wr_ctrl && bus_wdata[CB_EVRST];
    cy_clr   = wr_ctrl && bus_wdata[CB_CYRST];
  end

  for (genvar n = 0; n < NCNT; n++) begin : g_cnt
    pmu_evt_counter #(.EVT_W(EVT_W)) u_evt (
      .clk    (clk),
      .rst    (rst),
      .gate   (ctrl_e && cnten_q[n]),
      .evt    (evt_in),
      .priv   (priv_lvl),
      .typ_we (wr_type && (sel_q == 5'(n))),
      .cnt_we (wr_evcnt && (sel_q == 5'(n))),
      .clr    (ev_clr),
      .wdata  (bus_wdata),
      .cnt    (cnt_arr[n]),
      .typ    (typ_arr[n]),
      .wrap   (evt_wrap[n])
    );
  end

  pmu_cycle_counter #(.DIV_LOG2(6)) u_cyc (
    .clk    (clk),
    .rst    (rst),
    .gate   (ctrl_e && cnten_q[CYC_BIT]),
    .div_on (ctrl_d),
    .stall  (ctrl_dp && dbg_halt),
    .cnt_we (wr_cyc),
    .clr    (cy_clr),
    .wdata  (bus_wdata),
    .cnt    (cyc_cnt),
    .wrap   (cyc_wrap)
  );

  always_comb begin
    wrap_vec = '0;
    for (int n = 0; n < NCNT; n++) wrap_vec[n] = evt_wrap[n];
    wrap_vec[CYC_BIT] = cyc_wrap;
    ind_cnt = '0;
    ind_typ = '0;
    for (int n = 0; n < NCNT; n++) begin
      if (sel_q == 5'(n)) begin
        ind_cnt = cnt_arr[n];
        ind_typ = typ_arr[n];
      end
    end
    ctrl_rd = {16'd0, NCNT5, 5'd0, ctrl_dp, ctrl_x, ctrl_d, 2'b00, ctrl_e};
    unique case (bus_addr)
      A_CTRL:           rd_mux = ctrl_rd;
      A_SEL:            rd_mux = {27'd0, sel_q};
      A_TYPE:           rd_mux = ind_typ;
      A_EVCNT:          rd_mux = ind_cnt;
      A_CYC:            rd_mux = cyc_cnt;
      A_ENSET, A_ENCLR: rd_mux = cnten_q;
      A_IESET, A_IECLR: rd_mux = inten_q;
      A_OVF:            rd_mux = ovf_q;
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_e <= 1'b0; ctrl_d <= 1'b0; ctrl_x <= 1'b0; ctrl_dp <= 1'b0;
      sel_q <= '0; cnten_q <= '0; inten_q <= '0; ovf_q <= '0;
      rdata_q <= '0; irq_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_e  <= bus_wdata[CB_EN];
        ctrl_d  <= bus_wdata[CB_DIV];
        ctrl_x  <= bus_wdata[CB_SPARE];
        ctrl_dp <= bus_wdata[CB_DBGSTOP];
      end
      if (wr_sel) sel_q <= bus_wdata[4:0];
      if (bus_wr && bus_addr == A_ENSET) cnten_q <= cnten_q | (bus_wdata & CNT_MASK);
      if (bus_wr && bus_addr == A_ENCLR) cnten_q <= cnten_q & ~bus_wdata;
      if (bus_wr && bus_addr == A_IESET) inten_q <= inten_q | (bus_wdata & CNT_MASK);
      if (bus_wr && bus_addr == A_IECLR) inten_q <= inten_q & ~bus_wdata;
      ovf_q <= (ovf_q & ~(wr_ovf ? bus_wdata : 32'd0)) | wrap_vec;
      if (bus_rd) rdata_q <= rd_mux;
      irq_q <= |(ovf_q & inten_q);
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;

  AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
    (|wrap_vec) |=> ((ovf_q & $past(wrap_vec)) == $past(wrap_vec))); // R9
  AST_OVF_W1C: assert property (@(posedge clk) disable iff (rst)
    (wr_ovf && !(|wrap_vec)) |=> ((ovf_q & $past(bus_wdata)) == 32'd0)); // R9
  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ovf_q != 32'd0)); // R10
  AST_SEL_OOR: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr == A_EVCNT || bus_addr == A_TYPE) && sel_q >= NCNT5) |=> (bus_rdata == 32'd0)); // R11
  AST_EN_CLR: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_ENCLR) |=> ((cnten_q & $past(bus_wdata)) == 32'd0)); // R8
  AST_CTRL_RO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_CTRL) |=> (bus_rdata[15:11] == NCNT5 && bus_rdata[2:1] == 2'b00)); // R2
endmodule

// File: tb/perf_mon_unit_tb.sv
`timescale 1ns/1ps
module perf_mon_unit_tb;
  localparam int NC = 4;
  localparam int EW = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [EW-1:0] evt_in = 0;
  logic [1:0] priv_lvl = 0;
  logic dbg_halt = 0;
  logic irq;

  int total = 0, bad = 0;
  bit done = 0;

  perf_mon_unit #(.NCNT(NC), .EVT_W(EW)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
    .priv_lvl(priv_lvl), .dbg_halt(dbg_halt), .irq(irq));

  always #10 clk = ~clk;

  // Behavioural reference model
  bit [31:0] m_cnt [NC];
  bit [31:0] m_typ [NC];
  bit [31:0] m_cyc, m_cnten, m_inten, m_ovf, m_rd;
  int        m_presc;
  bit        m_e, m_d, m_x, m_dp, m_irq;
  int        m_sel;
  localparam bit [31:0] MASK = 32'h8000_0000 | ((32'd1 << NC) - 1);

  function automatic bit fpass(bit [31:0] t, bit [1:0] p);
    case (p)
      2'd0: return !t[30];
      2'd1: return !t[31];
      2'd2: return t[27];
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit [31:0] mread(bit [3:0] a);
    case (a)
      4'd0: return (32'(NC) << 11) | {26'd0, m_dp, m_x, m_d, 2'b00, m_e};
      4'd1: return 32'(m_sel);
      4'd2: return (m_sel < NC) ? m_typ[m_sel] : 32'd0;
      4'd3: return (m_sel < NC) ? m_cnt[m_sel] : 32'd0;
      4'd4: return m_cyc;
      4'd5, 4'd6: return m_cnten;
      4'd7, 4'd8: return m_inten;
      4'd9: return m_ovf;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < NC; n++) begin m_cnt[n] = 0; m_typ[n] = 0; end
      m_cyc = 0; m_cnten = 0; m_inten = 0; m_ovf = 0; m_rd = 0; m_presc = 0;
      m_e = 0; m_d = 0; m_x = 0; m_dp = 0; m_irq = 0; m_sel = 0;
    end else begin
      bit [31:0] wraps;
      bit pclr, cclr, irq_n, elig, step;
      wraps = 0;
      if (bus_rd) m_rd = mread(bus_addr);
      irq_n = |(m_ovf & m_inten);
      pclr = bus_wr && bus_addr == 0 && bus_wdata[1];
      cclr = bus_wr && bus_addr == 0 && bus_wdata[2];
      for (int n = 0; n < NC; n++) begin
        int ev;
        bit hit;
        ev = int'(m_typ[n][9:0]);
        hit = (ev < EW) ? evt_in[ev] : 1'b0;
        if (pclr) m_cnt[n] = 0;
        else if (bus_wr && bus_addr == 3 && m_sel == n) m_cnt[n] = bus_wdata;
        else if (m_e && m_cnten[n] && hit && fpass(m_typ[n], priv_lvl)) begin
          if (m_cnt[n] == 32'hFFFF_FFFF) wraps[n] = 1;
          m_cnt[n] = m_cnt[n] + 1;
        end
        if (bus_wr && bus_addr == 2 && m_sel == n) m_typ[n] = bus_wdata & 32'hC800_03FF;
      end
      elig = m_e && m_cnten[31] && !(m_dp && dbg_halt);
      step = elig && (!m_d || m_presc == 63);
      if (cclr) m_presc = 0;
      else if (elig && m_d) m_presc = (m_presc + 1) % 64;
      if (cclr) m_cyc = 0;
      else if (bus_wr && bus_addr == 4) m_cyc = bus_wdata;
      else if (step) begin
        if (m_cyc == 32'hFFFF_FFFF) wraps[31] = 1;
        m_cyc = m_cyc + 1;
      end
      if (bus_wr) begin
        case (bus_addr)
          4'd0: begin m_e = bus_wdata[0]; m_d = bus_wdata[3]; m_x = bus_wdata[4]; m_dp = bus_wdata[5]; end
          4'd1: m_sel = int'(bus_wdata[4:0]);
          4'd5: m_cnten = m_cnten | (bus_wdata & MASK);
          4'd6: m_cnten = m_cnten & ~bus_wdata;
          4'd7: m_inten = m_inten | (bus_wdata & MASK);
          4'd8: m_inten = m_inten & ~bus_wdata;
          default: ;
        endcase
      end
      m_ovf = (m_ovf & ~((bus_wr && bus_addr == 9) ? bus_wdata : 32'd0)) | wraps;
      m_irq = irq_n;
    end
  end

  // compare with the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      total++;
      if (bus_rdata !== m_rd) begin
        bad++;
        $display("FAIL R12 model rdata: actual=%h expected=%h", bus_rdata, m_rd);
      end
      total++;
      if (irq !== m_irq) begin
        bad++;
        $display("FAIL R10 model irq: actual=%0b expected=%0b", irq, m_irq);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 rdata", bus_rdata, 32'd0);
    rd(4'd0, 32'h0000_2000, "R1 ctrl");
    rd(4'd9, 32'd0, "R1 ovf");
    rd(4'd5, 32'd0, "R1 cnten");
    rd(4'd3, 32'd0, "R1 evcnt");
    // R2 control writable bits
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, 32'h0000_2039, "R2 ctrl mask");
    wr(4'd0, 32'd0);
    // R6 type mask
    wr(4'd1, 32'd0);
    wr(4'd2, 32'hFFFF_FFFF);
    rd(4'd2, 32'hC800_03FF, "R6 type mask");
    // R4 R5 counting with filter
    wr(4'd2, 32'd5);
    wr(4'd5, 32'h8000_0001);
    wr(4'd0, 32'd1);
    evt_in = 32'h20; priv_lvl = 0; idle(2);
    priv_lvl = 1; idle(1);
    priv_lvl = 2; idle(2);
    priv_lvl = 3; idle(1);
    evt_in = 0; priv_lvl = 0;
    wr(4'd0, 32'd0);
    rd(4'd3, 32'd3, "R5 filtered count");
    // R11 out of range select
    wr(4'd1, 32'd7);
    wr(4'd3, 32'h55);
    rd(4'd3, 32'd0, "R11 oor cnt");
    rd(4'd2, 32'd0, "R11 oor type");
    wr(4'd1, 32'd0);
    rd(4'd3, 32'd3, "R11 cnt untouched");
    // R9 R10 overflow and interrupt
    wr(4'd1, 32'd1);
    wr(4'd2, 32'h0800_0002);
    wr(4'd3, 32'hFFFF_FFFE);
    wr(4'd7, 32'd2);
    wr(4'd5, 32'd2);
    wr(4'd0, 32'd1);
    evt_in = 32'h4; priv_lvl = 2; idle(2);
    evt_in = 0; priv_lvl = 0;
    wr(4'd0, 32'd0);
    chk("R10 irq high", {31'd0, irq}, 32'd1);
    rd(4'd9, 32'd2, "R9 ovf flag");
    rd(4'd3, 32'd0, "R9 wrapped");
    wr(4'd9, 32'd2);
    idle(1);
    chk("R10 irq low", {31'd0, irq}, 32'd0);
    rd(4'd9, 32'd0, "R9 w1c");
    // R8 set and clear
    wr(4'd6, 32'd1);
    rd(4'd5, 32'h8000_0002, "R8 set reg");
    rd(4'd6, 32'h8000_0002, "R8 clr reg");
    // R7 R3 cycle counter
    wr(4'd0, 32'd4);
    rd(4'd4, 32'd0, "R3 cyc reset");
    wr(4'd0, 32'd1);
    idle(9);
    wr(4'd0, 32'd0);
    rd(4'd4, 32'd10, "R7 cyc plain");
    wr(4'd0, 32'd4);
    wr(4'd0, 32'd9);
    idle(64);
    wr(4'd0, 32'd0);
    rd(4'd4, 32'd1, "R7 cyc div64");
    wr(4'd0, 32'd4);
    wr(4'd0, 32'h21);
    dbg_halt = 1; idle(5);
    dbg_halt = 0;
    wr(4'd0, 32'd0);
    rd(4'd4, 32'd1, "R7 cyc stall");
    wr(4'd1, 32'd0);
    wr(4'd0, 32'd2);
    rd(4'd3, 32'd0, "R3 evt reset");
    // R4 event number beyond the bus
    wr(4'd2, 32'h3FF);
    wr(4'd5, 32'd1);
    wr(4'd0, 32'd1);
    evt_in = '1; idle(3);
    evt_in = 0;
    wr(4'd0, 32'd0);
    rd(4'd3, 32'd0, "R4 evnum out of range");
    // R12 write beats increment
    wr(4'd2, 32'd5);
    wr(4'd0, 32'd1);
    evt_in = 32'h20;
    wr(4'd3, 32'd100);
    evt_in = 0;
    wr(4'd0, 32'd0);
    rd(4'd3, 32'd100, "R12 write precedence");
    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      evt_in = $urandom;
      priv_lvl = 2'($urandom % 4);
      dbg_halt = ($urandom % 8) == 0;
      bus_rd = ($urandom % 4) == 0;
      bus_addr = 4'($urandom % 10);
      bus_wr = 0;
      r = $urandom % 6;
      if (r == 0) begin
        bus_wr = 1;
        case (bus_addr)
          4'd0: bus_wdata = (($urandom % 4) != 0) ? ($urandom | 32'd1) : $urandom;
          4'd2: bus_wdata = $urandom & 32'hC800_001F;
          4'd3, 4'd4: bus_wdata = 32'hFFFF_FFF0 | ($urandom % 16);
          default: bus_wdata = $urandom;
        endcase
      end
      @(negedge clk);
    end
    bus_wr = 0; bus_rd = 0;
    idle(2);
    finish_run();
  end
endmodule